// File: doc/BRIEF.md
# Expansion-Port I/O Chip-Select Decoder

This block sits on the expansion connector of an 8-bit home computer and turns raw bus activity into clean select and event signals for a small peripheral with four registers. It oversamples the address, R/W, PHI2, BA and MUX lines with a fast system clock. From these it decides whether the current bus cycle targets its four-byte window. Two board jumpers are also synchronized: one picks between two base addresses and the other switches the port off completely.

Writes are qualified by plain PHI2 high. Reads are qualified more strictly. They need BA high, so the video chip's bus-steal cycles are never mistaken for CPU reads. They also need R/W high and a copy of PHI2 that has been delayed by a parameter-selected number of clock stages. A build-time option replaces the delayed PHI2 with MUX low.

For each bus cycle that hits the window, the peripheral logic receives exactly one single-clock read or write pulse. It also receives the register index, which is taken at the moment the qualified select begins.

Top module: `exp_io_decoder`

## Requirements
- R1: A selection requires address bits 15 down to 11 all high. Any address with one of those bits low leaves `cs_n` and `buf_oe_n` high and produces no event.
- R2: With `base_sel`=0 the window is 0xFDF0 to 0xFDF3. With `base_sel`=1 it is 0xFD90 to 0xFD93. Bits 10..4 must match the chosen base and bits 3..2 must be zero.
- R3: While `port_off`=1 the block never asserts `cs_n` or `buf_oe_n` and emits no event.
- R4: `reg_idx` equals address bits 1..0 from the first cycle of a qualified select. It stays unchanged while `cs_n` remains low.
- R5: `buf_oe_n` is low exactly when the synchronized address lies inside the window. This takes two clocks of input latency.
- R6: A write (`bus_rw`=0) in the window drives `cs_n` low two clocks after PHI2 rises. BA and MUX have no effect on this.
- R7: A read (`bus_rw`=1) in the window drives `cs_n` low only while BA is high. In the default mode the select appears 2+DLY clocks after PHI2 rises. A read cycle with BA low gives no select and no event.
- R8: With READ_MUX=1, reads are qualified by MUX low instead of delayed PHI2. A read with MUX held high then gives no event.
- R9: Each bus cycle in the window yields exactly one single-clock pulse, on `rd_pulse` for reads or on `wr_pulse` for writes. This holds even when BA drops and returns during the PHI2 high phase.
- R10: When BA drops during a read select, `cs_n` rises two clocks after the pin change.
- R11: During reset and right after it, `cs_n` and `buf_oe_n` are high and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Expansion bus address A15..A0 |
| bus_rw | input | 1 | Bus R/W, high for read |
| bus_phi2 | input | 1 | Bus phase-2 clock |
| bus_ba | input | 1 | Bus available, low during video bus steal |
| bus_mux | input | 1 | Memory multiplex strobe |
| base_sel | input | 1 | Base jumper: 0 selects 0xFDF0, 1 selects 0xFD90 |
| port_off | input | 1 | Disable jumper, 1 forces no selection |
| cs_n | output | 1 | Active-low peripheral chip select |
| reg_idx | output | 2 | Register index within the window |
| buf_oe_n | output | 1 | Active-low data buffer enable |
| rd_pulse | output | 1 | Single-clock read event |
| wr_pulse | output | 1 | Single-clock write event |

## Verification
The read event and the loss of BA can land in the same cycle. This happens when the delayed PHI2 reaches the select while BA is falling. A correct design must produce one pulse when the qualification returns, and never two. The bench provokes this with a random one-clock BA glitch in the middle of read cycles. It judges the result by counting `rd_pulse` over the whole bus cycle and by checking that `cs_n` rises two clocks after the glitch begins. Directed and random cycles also vary the base jumper, the disable jumper and the read/write direction. They compare select latency, register index and buffer enable against values that bench functions compute.

// File: rtl/exp_io_decoder.sv
module exp_io_decoder #(
  parameter int DLY = 2,
  parameter bit READ_MUX = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_addr,
  input  logic        bus_rw,
  input  logic        bus_phi2,
  input  logic        bus_ba,
  input  logic        bus_mux,
  input  logic        base_sel,
  input  logic        port_off,
  output logic        cs_n,
  output logic [1:0]  reg_idx,
  output logic        buf_oe_n,
  output logic        rd_pulse,
  output logic        wr_pulse
);
  localparam int SW = 22;

  logic [SW-1:0] s1, s2;
  wire  [SW-1:0] raw = {bus_addr, bus_rw, bus_phi2, bus_ba, bus_mux, base_sel, port_off};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  wire [15:0] a_s   = s2[21:6];
  wire        rw_s  = s2[5];
  wire        phi_s = s2[4];
  wire        ba_s  = s2[3];
  wire        mux_s = s2[2];
  wire        bse_s = s2[1];
  wire        off_s = s2[0];

  logic phi_dly;
  generate
    if (DLY == 0) begin : g_nodly
      assign phi_dly = phi_s;
    end else begin : g_dly
      logic [DLY-1:0] dl;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) dl <= '0;
        else begin
          dl[0] <= phi_s;
          for (int i = 1; i < DLY; i++) dl[i] <= dl[i-1];
        end
      assign phi_dly = dl[DLY-1];
    end
  endgenerate

  wire [6:0] pat = bse_s ? 7'b1011001 : 7'b1011111;
  wire hit = ~off_s & (&a_s[15:11]) & (a_s[10:4] == pat) & (a_s[3:2] == 2'b00);
  wire rd_gate = READ_MUX ? ~mux_s : phi_dly;
  wire rd_qual = hit & rw_s & ba_s & rd_gate;
  wire wr_qual = hit & ~rw_s & phi_s;
  wire sel = rd_qual | wr_qual;

  logic armed, sel_q;
  logic [1:0] idx_q;

  assign cs_n     = ~sel;
  assign buf_oe_n = ~hit;
  assign reg_idx  = (sel & ~sel_q) ? a_s[1:0] : idx_q;
  assign rd_pulse = rd_qual & armed;
  assign wr_pulse = wr_qual & armed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b1;
      sel_q <= 1'b0;
      idx_q <= 2'b00;
    end else begin
      sel_q <= sel;
      idx_q <= reg_idx;
      if (rd_pulse | wr_pulse) armed <= 1'b0;
      else if (!phi_s && !sel) armed <= 1'b1;
    end

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse | wr_pulse) |=> !(rd_pulse | wr_pulse));
  p_excl_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_pulse && wr_pulse));
  p_cs_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !buf_oe_n);
  p_pulse_with_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse | wr_pulse) |-> !cs_n);
  p_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(reg_idx));
endmodule

// File: tb/tb_exp_io_decoder.sv
module tb_exp_io_decoder;
  localparam int DLY = 2;
  logic clk = 0, rst_n = 0;
  logic [15:0] addr = 0;
  logic rw = 1, phi2 = 0, ba = 1, mux = 1, base = 0, off = 0;
  logic cs_n, buf_oe_n, rdp, wrp, cs_n_m, oe_m, rdp_m, wrp_m;
  logic [1:0] idx, idx_m;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  exp_io_decoder #(.DLY(DLY), .READ_MUX(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rw(rw), .bus_phi2(phi2),
    .bus_ba(ba), .bus_mux(mux), .base_sel(base), .port_off(off),
    .cs_n(cs_n), .reg_idx(idx), .buf_oe_n(buf_oe_n), .rd_pulse(rdp), .wr_pulse(wrp));

  exp_io_decoder #(.DLY(DLY), .READ_MUX(1'b1)) dut_m (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rw(rw), .bus_phi2(phi2),
    .bus_ba(ba), .bus_mux(mux), .base_sel(base), .port_off(off),
    .cs_n(cs_n_m), .reg_idx(idx_m), .buf_oe_n(oe_m), .rd_pulse(rdp_m), .wr_pulse(wrp_m));

  function automatic bit exp_hit(input logic [15:0] a, input logic b, input logic o);
    logic [15:0] base_a = b ? 16'hFD90 : 16'hFDF0;
    return !o && (a[15:2] == base_a[15:2]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_cyc(input logic [15:0] a, input logic r, input logic b, input logic m,
                         input bit glitch);
    bit h = exp_hit(a, base, off);
    bit es = h && (!r || b);
    int rc = 0, wc = 0, mc = 0, lat = -1, gcs = -1;
    @(negedge clk);
    addr = a; rw = r; ba = b; mux = m; phi2 = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      mc += rdp_m + wrp_m;
    end
    chk(buf_oe_n == !h, h ? "R2/R5 in-window oe" : "R1/R3/R5 out-of-window oe", buf_oe_n, !h);
    phi2 = 1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      rc += rdp; wc += wrp; mc += rdp_m + wrp_m;
      if (!cs_n && lat < 0) begin
        lat = k;
        chk(idx == a[1:0], "R4 reg_idx", idx, a[1:0]);
      end
      if (glitch && k == 8) gcs = cs_n;
      if (glitch && k == 6) ba = 0;
      if (glitch && k == 7) ba = 1;
    end
    phi2 = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rc += rdp; wc += wrp; mc += rdp_m + wrp_m;
    end
    mux = 1;
    chk(rc == (es && r), r ? "R7/R9 read pulse count" : "R6 no read pulse", rc, es && r);
    chk(wc == (es && !r), r ? "R9 no write pulse" : "R6/R9 write pulse count", wc, es && !r);
    if (es) chk(lat == (r ? 2 + DLY : 2), r ? "R7 read latency" : "R6 write latency", lat, r ? 2 + DLY : 2);
    else chk(lat == -1, "R1/R3/R7 no select", lat, -1);
    if (glitch && es && r) chk(gcs == 1, "R10 cs drop on BA", gcs, 1);
    if (r) chk(mc == (h && b && !m), "R8 mux mode read", mc, h && b && !m);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    join_none
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(cs_n && buf_oe_n && !rdp && !wrp, "R11 reset state", {cs_n, buf_oe_n, rdp, wrp}, 4'b1100);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && buf_oe_n && !rdp && !wrp, "R11 after reset", {cs_n, buf_oe_n, rdp, wrp}, 4'b1100);
    base = 0; off = 0;
    bus_cyc(16'hFDF0, 0, 1, 1, 0);
    bus_cyc(16'hFDF3, 1, 1, 1, 0);
    bus_cyc(16'hFDF2, 1, 0, 1, 0);
    bus_cyc(16'hFDF1, 1, 1, 1, 1);
    bus_cyc(16'h7DF0, 1, 1, 1, 0);
    bus_cyc(16'hFDF4, 0, 1, 1, 0);
    bus_cyc(16'hFD91, 0, 1, 1, 0);
    bus_cyc(16'hFDF2, 0, 0, 0, 0);
    bus_cyc(16'hFDF1, 1, 1, 0, 0);
    base = 1;
    bus_cyc(16'hFD92, 1, 1, 1, 0);
    bus_cyc(16'hFDF2, 1, 1, 1, 0);
    off = 1;
    bus_cyc(16'hFD93, 0, 1, 1, 0);
    bus_cyc(16'hFD90, 1, 1, 0, 0);
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      logic r, b, m;
      bit g;
      base = $urandom_range(0, 1);
      off = ($urandom_range(0, 7) == 0);
      a = $urandom_range(0, 2) != 0 ? (base ? 16'hFD90 : 16'hFDF0) | 16'($urandom_range(0, 3))
                                    : 16'($urandom);
      r = $urandom_range(0, 1);
      b = $urandom_range(0, 3) != 0;
      m = $urandom_range(0, 1);
      g = r && b && $urandom_range(0, 1);
      bus_cyc(a, r, b, m, g);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule